// File: doc/BRIEF.md
# Console Serial Register Front End

This block is the byte-wide register face of a minimal serial console in the style of the classic single-character serial port. A processor reaches it over a small memory-mapped bus: a 3-bit offset, a read strobe, a write strobe, a write byte and a read byte. The read byte is combinational and follows the offset in the same cycle. Every side effect of an access takes place at the clock edge that ends that access. The far side of the console is two byte streams with valid/ready handshakes. The inbound stream supplies characters, and the block holds one of them at a time. The outbound stream carries the characters that software writes.

A single interrupt line reports two internal conditions: a held received character, and transmit completion. Transmit completion is not reported at once. Each character write starts a countdown of `TX_DELAY` cycles (300 by default). When the countdown expires, the transmit condition is raised, provided the transmit-empty enable is set. This timing lets a driver that expects a real line's latency see a realistic gap between writing a character and being told it is done. A later write restarts the countdown, and clearing the enable cancels it.

Top module: `ser_console_regs`

## Requirements
- R1: A read at offset 5 (line status) returns bits 6, 5 and 2 set and bits 7, 4, 3 and 1 clear, that is 0x64. Bit 0 is 1 when a received character is held.
- R2: A line-status read while no character is held asserts `rx_ready` in that cycle. If `rx_valid` is high, the byte is captured into the hold register and bit 0 of that same read is 1. A line-status read while a character is held asserts `rx_ready` nowhere and reports bit 0 as 1.
- R3: A read at offset 0 returns the held byte and clears the held flag. The next line-status read then fetches again.
- R4: Internal status is a 2-bit code, with transmit at 0x01 and receive (character held) at 0x02. `irq` is the OR of both bits. A read at offset 2 returns 0 in bits 7..1, and returns bit 0 as 0 when either status bit is set and 1 otherwise.
- R5: A write at offset 0 passes the byte to the outbound stream when its value is below 0x80 (printable or control) and is not 0x0C. Other bytes are dropped.
- R6: An outbound byte holds `tx_valid` and `tx_data` steady until `tx_ready` is seen. A newer accepted write replaces a byte that is still waiting.
- R7: A write at offset 0 clears the transmit status at once and starts a countdown. The transmit status is set `TX_DELAY` clock edges after the write edge, and only if the transmit-empty enable is 1 at that time.
- R8: A write at offset 0 while the countdown runs restarts it at the full `TX_DELAY`.
- R9: A write at offset 1 stores the transmit-empty enable from bit 1. If that bit is 1, the transmit status is set at the next edge. If it is 0, the transmit status is cleared and any running countdown is cancelled.
- R10: Reads at offsets 1, 3, 4, 6 and 7 return 0, and writes to offsets 2 through 7 leave all state unchanged.
- R11: The synchronous active-high `rst` clears the held character and its flag, the enable bit, both status bits, the pending outbound byte and the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| rx_data | input | 8 | Inbound character |
| rx_valid | input | 1 | Inbound character available |
| rx_ready | output | 1 | Inbound character taken this cycle |
| tx_data | output | 8 | Outbound character |
| tx_valid | output | 1 | Outbound character pending |
| tx_ready | input | 1 | Outbound consumer accepts |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the bus never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that both strobes and the offset are known and steady around each edge. The stimulus meets both conditions: every access changes its inputs only on the falling edge, and the access tasks drive one strobe at a time. The inbound stream is assumed to hold `rx_data` steady while `rx_valid` is high, and the bench changes that byte only while no line-status read is in progress.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    localparam int BYTE_W = 8;

    // register offsets the bus decodes
    localparam int OFS_DATA = 0;
    localparam int OFS_IEN  = 1;
    localparam int OFS_IID  = 2;
    localparam int OFS_LST  = 5;

    // fixed always-ready bits reported by line status
    localparam logic [BYTE_W-1:0] LST_FIXED = 8'h64;

    // bit of the enable register that arms the transmit condition
    localparam int IEN_TXE_BIT = 1;

    // status code: transmit = 0x01, receive = 0x02
    typedef struct packed {
        logic rx;
        logic tx;
    } int_stat_t;

    typedef struct packed {
        logic wr_data;
        logic wr_ien;
        logic rd_data;
        logic rd_lst;
        logic rd_iid;
    } bus_dec_t;

    function automatic logic tx_char_ok(input logic [BYTE_W-1:0] b);
        return (b < 8'h80) && (b != 8'h0C);
    endfunction

endpackage

// File: rtl/sercon_rx_hold.sv
module sercon_rx_hold
    import sercon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lst_read,
    input  logic              data_read,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              held_valid,
    output logic [BYTE_W-1:0] held_char,
    output logic              lst_rx_bit
);

    logic fetch_now;

    assign rx_ready   = lst_read && !held_valid;
    assign fetch_now  = rx_ready && rx_valid;
    assign lst_rx_bit = held_valid || fetch_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_char  <= '0;
        end else if (fetch_now) begin
            held_valid <= 1'b1;
            held_char  <= rx_data;
        end else if (data_read) begin
            held_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sercon_tx_path.sv
module sercon_tx_path
    import sercon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid
);

    logic accept;

    assign accept = wr_en && tx_char_ok(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (accept) begin
            tx_valid <= 1'b1;
            tx_data  <= wdata;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sercon_tx_timer.sv
module sercon_tx_timer #(
    parameter int TX_DELAY = 300,
    localparam int CNT_W   = $clog2(TX_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cancel,
    output logic             expire,
    output logic             running,
    output logic [CNT_W-1:0] count
);

    logic last;

    assign last   = running && (count == CNT_W'(1));
    assign expire = last && !start && !cancel;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            running <= 1'b0;
            count   <= '0;
        end else if (start) begin
            running <= 1'b1;
            count   <= CNT_W'(TX_DELAY);
        end else if (running) begin
            count <= count - CNT_W'(1);
            if (last) running <= 1'b0;
        end
    end

endmodule

// File: rtl/ser_console_regs.sv
module ser_console_regs
    import sercon_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int TX_DELAY = 300,
    localparam int CNT_W   = $clog2(TX_DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);

    bus_dec_t          dec;
    int_stat_t         stat;
    logic              ien_txe;
    logic              held_valid;
    logic [BYTE_W-1:0] held_char;
    logic              lst_rx_bit;
    logic              tmr_expire;
    logic              tmr_run;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_cancel;

    always_comb begin
        dec.wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
        dec.wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
        dec.rd_data = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));
        dec.rd_lst  = bus_rd && (bus_addr == ADDR_W'(OFS_LST));
        dec.rd_iid  = bus_rd && (bus_addr == ADDR_W'(OFS_IID));
    end

    sercon_rx_hold u_rx (
        .clk        (clk),
        .rst        (rst),
        .lst_read   (dec.rd_lst),
        .data_read  (dec.rd_data),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .held_valid (held_valid),
        .held_char  (held_char),
        .lst_rx_bit (lst_rx_bit)
    );

    sercon_tx_path u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dec.wr_data),
        .wdata    (bus_wdata),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid)
    );

    assign tmr_cancel = dec.wr_ien && !bus_wdata[IEN_TXE_BIT];

    sercon_tx_timer #(.TX_DELAY(TX_DELAY)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (dec.wr_data),
        .cancel  (tmr_cancel),
        .expire  (tmr_expire),
        .running (tmr_run),
        .count   (tmr_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_txe <= 1'b0;
            stat.tx <= 1'b0;
        end else if (dec.wr_ien) begin
            ien_txe <= bus_wdata[IEN_TXE_BIT];
            stat.tx <= bus_wdata[IEN_TXE_BIT];
        end else if (dec.wr_data) begin
            stat.tx <= 1'b0;
        end else if (tmr_expire) begin
            stat.tx <= ien_txe;
        end
    end

    assign stat.rx = held_valid;
    assign irq     = |stat;

    always_comb begin
        bus_rdata = '0;
        if (dec.rd_data)     bus_rdata = held_char;
        else if (dec.rd_lst) bus_rdata = LST_FIXED | {7'b0, lst_rx_bit};
        else if (dec.rd_iid) bus_rdata = {7'b0, ~(|stat)};
    end

endmodule

// File: rtl/sercon_checker.sv
module sercon_checker #(
    parameter int ADDR_W   = 3,
    parameter int TX_DELAY = 300,
    localparam int CNT_W   = $clog2(TX_DELAY + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq,
    input logic              held_valid,
    input logic              tx_stat,
    input logic              tmr_run,
    input logic [CNT_W-1:0]  tmr_cnt
);

    p_lst_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(5)) |-> (bus_rdata[7:1] == 7'h32));

    p_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_valid) |=> held_valid);

    p_take_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(0)) |=> !held_valid);

    p_iid_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(2)) |-> (bus_rdata == {7'b0, !irq}));

    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !(bus_wr && bus_addr == ADDR_W'(0)))
        |=> (tx_valid && $stable(tx_data)));

    p_tx_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> !tx_stat);

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (tmr_run && tmr_cnt == CNT_W'(TX_DELAY)));

    p_ien_on_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[1]) |=> tx_stat);

    p_ien_off_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(1) && !bus_wdata[1]) |=> (!tx_stat && !tmr_run));

    p_unlisted_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(7))) |-> (bus_rdata == 8'h00));

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!irq && !tx_valid && !tmr_run));

endmodule

bind ser_console_regs sercon_checker #(.ADDR_W(ADDR_W), .TX_DELAY(TX_DELAY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .irq        (irq),
    .held_valid (held_valid),
    .tx_stat    (stat.tx),
    .tmr_run    (tmr_run),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/test_ser_console_regs.sv
`timescale 1ns/1ps
module test_ser_console_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_q[$];
    logic       seen_rx_ready;
    logic [7:0] rd_val;

    always #4 clk = ~clk;

    ser_console_regs i_ser_console_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        seen_rx_ready = rx_ready;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: predicts the outbound stream
    task automatic send_char(input logic [7:0] c);
        if (c < 8'h80 && c != 8'h0C) exp_q.push_back(c);
        bus_write(3'd0, c);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // monitor: pops the scoreboard on each outbound handshake
    always @(negedge clk) begin
        #1;
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R5: actual %h expected none", tx_data);
            end else begin
                check("R5 outbound byte", tx_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #800000;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        wait_cycles(3);
        @(negedge clk); rst = 1'b0;
        wait_cycles(1);

        // R11 reset state
        check("R11 irq after reset", {7'b0, irq}, 8'h00);
        check("R11 tx_valid after reset", {7'b0, tx_valid}, 8'h00);
        bus_read(3'd2, rd_val);
        check("R4 iid idle", rd_val, 8'h01);
        bus_read(3'd5, rd_val);
        check("R1 lst empty", rd_val, 8'h64);
        check("R2 rx_ready on empty lst read", {7'b0, seen_rx_ready}, 8'h01);

        // R2 fetch, R1 bit 0
        rx_data = 8'h41; rx_valid = 1'b1;
        bus_read(3'd5, rd_val);
        check("R1 lst with fetch", rd_val, 8'h65);
        rx_valid = 1'b0;
        #1;
        check("R4 irq on held char", {7'b0, irq}, 8'h01);
        bus_read(3'd2, rd_val);
        check("R4 iid pending", rd_val, 8'h00);
        rx_data = 8'h42; rx_valid = 1'b1;
        bus_read(3'd5, rd_val);
        check("R2 lst while held", rd_val, 8'h65);
        check("R2 no rx_ready while held", {7'b0, seen_rx_ready}, 8'h00);
        rx_valid = 1'b0;

        // R3 data read
        bus_read(3'd0, rd_val);
        check("R3 held char", rd_val, 8'h41);
        #1;
        check("R3 irq clears", {7'b0, irq}, 8'h00);
        bus_read(3'd5, rd_val);
        check("R3 lst after take", rd_val, 8'h64);

        // R10 unlisted offsets
        bus_write(3'd1, 8'h02);
        bus_read(3'd1, rd_val);
        check("R10 read offset 1", rd_val, 8'h00);
        bus_read(3'd3, rd_val);
        check("R10 read offset 3", rd_val, 8'h00);
        bus_read(3'd7, rd_val);
        check("R10 read offset 7", rd_val, 8'h00);
        bus_write(3'd1, 8'h00);
        bus_write(3'd3, 8'hFF);
        bus_write(3'd2, 8'h02);
        wait_cycles(1);
        check("R10 write ignored irq", {7'b0, irq}, 8'h00);
        check("R10 write ignored tx", {7'b0, tx_valid}, 8'h00);

        // R5 filter
        send_char(8'h48); send_char(8'h0A); send_char(8'h0C);
        send_char(8'h85); send_char(8'h7F);
        wait_cycles(2);
        check("R5 queue drained", 8'(exp_q.size()), 8'h00);

        // R6 backpressure and replacement
        @(negedge clk); tx_ready = 1'b0;
        bus_write(3'd0, 8'h61);
        wait_cycles(3);
        check("R6 valid held", {7'b0, tx_valid}, 8'h01);
        check("R6 data held", tx_data, 8'h61);
        send_char(8'h62);
        wait_cycles(1);
        check("R6 replaced byte", tx_data, 8'h62);
        @(negedge clk); tx_ready = 1'b1;
        wait_cycles(2);
        check("R6 delivered", {7'b0, tx_valid}, 8'h00);

        // R7 expiry with enable clear: no interrupt
        wait_cycles(400);
        check("R7 disabled expiry", {7'b0, irq}, 8'h00);

        // R9 enable raises at once
        bus_write(3'd1, 8'h02);
        #1;
        check("R9 enable raises", {7'b0, irq}, 8'h01);

        // R7 delay timing
        send_char(8'h31);
        #1;
        check("R7 write clears", {7'b0, irq}, 8'h00);
        wait_cycles(299);
        check("R7 before delay", {7'b0, irq}, 8'h00);
        wait_cycles(1);
        check("R7 at delay", {7'b0, irq}, 8'h01);

        // R8 restart
        send_char(8'h32);
        wait_cycles(200);
        send_char(8'h33);
        wait_cycles(150);
        check("R8 old deadline ignored", {7'b0, irq}, 8'h00);
        wait_cycles(149);
        check("R8 before new deadline", {7'b0, irq}, 8'h00);
        wait_cycles(1);
        check("R8 at new deadline", {7'b0, irq}, 8'h01);

        // R9 disable cancels
        send_char(8'h34);
        wait_cycles(100);
        bus_write(3'd1, 8'h00);
        #1;
        check("R9 disable clears", {7'b0, irq}, 8'h00);
        bus_write(3'd1, 8'h00);
        wait_cycles(1);
        bus_write(3'd1, 8'h00);
        wait_cycles(400);
        check("R9 cancelled timer silent", {7'b0, irq}, 8'h00);

        // R11 reset mid-countdown with held char
        bus_write(3'd1, 8'h02);
        rx_data = 8'h55; rx_valid = 1'b1;
        bus_read(3'd5, rd_val);
        rx_valid = 1'b0;
        send_char(8'h35);
        wait_cycles(2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R11 irq after mid reset", {7'b0, irq}, 8'h00);
        wait_cycles(400);
        check("R11 timer cleared", {7'b0, irq}, 8'h00);
        bus_read(3'd5, rd_val);
        check("R11 held cleared", rd_val, 8'h64);
        bus_write(3'd0, 8'h36);
        exp_q.push_back(8'h36);
        wait_cycles(400);
        check("R11 enable cleared", {7'b0, irq}, 8'h00);
        check("R5 final queue", 8'(exp_q.size()), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule